// File: doc/BRIEF.md
# Single-Frame Byte-Port Network Interface

This block is a network interface that a host drives entirely through a small register bus. It has two byte buffers. One holds the latest frame taken from an incoming byte stream. The other collects an outgoing frame. The host drains the received frame one byte per read of a data port. It fills the outgoing frame one byte per write of another data port, after it has announced the length. When the last announced byte is written, the frame leaves on a byte stream with valid/ready/last handshaking.

Completion events are reported in an interrupt control register that has two event flags and a self-clearing test flag. A single level interrupt follows that register. A busy flag gates reception. It rises whenever a frame is accepted or launched. It is recomputed from the interrupt flags on every write to interrupt control. The host therefore re-arms reception by acknowledging events. Writing the test flag performs a soft reset of the counters and pointers and leaves the test flag raised.

Register reads return data combinationally in the strobe cycle. Side effects of a read or a write take place at the clock edge that ends that cycle.

Top module: `frame_port_nic`

## Requirements
- R1: Reading offset 0x00 returns 0x4D495053 and offset 0x04 returns 0x4E455430. Offset 0x18, the transmit data port 0x20 and every unmapped offset read as 0. Reads return 0 when no read strobe is active.
- R2: After hardware reset, busy (offset 0x08, bit 0) reads 1. The receive count (0x0C), transmit count (0x10) and interrupt control (0x14) read 0. The interrupt and txValid are low.
- R3: Interrupt control holds TX-done at bit 0, RX-done at bit 1 and the test flag at bit 31. The interrupt output is high exactly when at least one of these bits is set.
- R4: A read of interrupt control returns its current value and clears the test flag afterwards.
- R5: A write to interrupt control acts on one flag only. Bit 0 set clears TX-done. Otherwise bit 1 set clears RX-done. Otherwise bit 31 set triggers the soft reset. A zero value changes no flag. After any such write, busy equals the OR of the resulting flags.
- R6: The soft reset zeroes the receive count, receive read pointer, transmit count and transmit write pointer. It leaves only the test flag set in interrupt control, with busy at 1.
- R7: A write to the transmit count stores the value when it is at most 1514 and stores 0 otherwise. In both cases the transmit write pointer returns to 0.
- R8: Each transmit data write (offset 0x20) stores the low byte at the write pointer and advances the pointer. The write that brings the pointer to the count launches the frame on the output stream in write order, with txLast on the final byte. The same write zeroes the count, sets TX-done and sets busy. A data write while the count is 0 has no effect.
- R9: While a launched frame is on the output stream, txValid, txData and txLast hold whenever txReady is low. Writes to the transmit count and data port are ignored until the last byte is taken.
- R10: An incoming frame whose first byte arrives with busy clear and receive count below 1514 is accepted. Acceptance sets busy. At the last byte, the receive count becomes the frame length, the read pointer is 0 and RX-done is set.
- R11: An incoming frame that starts while busy is set is discarded completely. The receive count and RX-done are unchanged.
- R12: Each read of the receive data port (0x1C) returns the next stored byte in the low 8 bits and decrements the receive count. With a count of 0 it returns 0 and changes nothing.
- R13: An incoming frame longer than 1514 bytes keeps its first 1514 bytes and reports a count of 1514.
- R14: When a host write to interrupt control falls in the same cycle as the last byte of an accepted incoming frame, both take effect. The written flag is cleared, RX-done is set, and busy ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 6 | Register byte offset |
| regRd | input | 1 | Read strobe |
| regWr | input | 1 | Write strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the strobe cycle |
| rxValid | input | 1 | Incoming byte valid |
| rxData | input | 8 | Incoming byte |
| rxLast | input | 1 | Incoming byte ends the frame |
| txValid | output | 1 | Outgoing byte valid |
| txReady | input | 1 | Downstream accepts the outgoing byte |
| txData | output | 8 | Outgoing byte |
| txLast | output | 1 | Outgoing byte ends the frame |
| irq | output | 1 | Level interrupt |

## Verification
The delicate overlap is between the end of an incoming frame and a host write to interrupt control. The incoming frame raises RX-done and busy. The write clears one flag and recomputes busy from the result. The bench runs two concurrent threads. One streams a twenty-byte frame. The other first launches a one-byte transmit frame so that TX-done is set, then places an acknowledge of TX-done on exactly the cycle that carries rxLast. After that cycle, interrupt control must read 0x2, busy must read 1, and the receive count must show the full frame length. That result shows the acknowledge did not erase the event that arrived with it.

// File: rtl/fpn_pkg.sv
package fpn_pkg;
  localparam int FRAME_MAX = 1514;
  localparam int PTR_W     = $clog2(FRAME_MAX + 1);
  localparam int ADDR_W    = 6;
  localparam int NUM_BUF   = 2;

  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(FRAME_MAX);

  localparam logic [ADDR_W-1:0] OFS_ID0   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_ID1   = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_BUSY  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_RXCNT = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_TXCNT = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_ICTL  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_RXDAT = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_TXDAT = 6'h20;

  localparam logic [31:0] ID_WORD0 = 32'h4D495053;
  localparam logic [31:0] ID_WORD1 = 32'h4E455430;

  typedef struct packed {
    logic             rxWe;
    logic [PTR_W-1:0] rxWa;
    logic [PTR_W-1:0] rxRa;
    logic             txWe;
    logic [PTR_W-1:0] txWa;
    logic [PTR_W-1:0] txRa;
  } bufStrobe_t;
endpackage

// File: rtl/fpn_bytebuf.sv
module fpn_bytebuf #(
  parameter int DEPTH = 1514,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [7:0]    wd,
  input  logic [AW-1:0] ra,
  output logic [7:0]    rd
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd = mem[ra];
endmodule

// File: rtl/fpn_datapath.sv
module fpn_datapath
  import fpn_pkg::*;
(
  input  logic       clk,
  input  bufStrobe_t strobe,
  input  logic [7:0] rxData,
  input  logic [7:0] hostByte,
  output logic [7:0] rxByte,
  output logic [7:0] txByte
);
  logic             weV [NUM_BUF];
  logic [PTR_W-1:0] waV [NUM_BUF];
  logic [PTR_W-1:0] raV [NUM_BUF];
  logic [7:0]       wdV [NUM_BUF];
  logic [7:0]       rdV [NUM_BUF];

  // buffer 0 holds the received frame, buffer 1 the outgoing frame
  always_comb begin
    weV[0] = strobe.rxWe;  waV[0] = strobe.rxWa;  raV[0] = strobe.rxRa;  wdV[0] = rxData;
    weV[1] = strobe.txWe;  waV[1] = strobe.txWa;  raV[1] = strobe.txRa;  wdV[1] = hostByte;
  end

  for (genvar g = 0; g < NUM_BUF; g++) begin : gBuf
    fpn_bytebuf #(.DEPTH(FRAME_MAX), .AW(PTR_W)) bufI (
      .clk (clk),
      .we  (weV[g]),
      .wa  (waV[g]),
      .wd  (wdV[g]),
      .ra  (raV[g]),
      .rd  (rdV[g])
    );
  end

  assign rxByte = rdV[0];
  assign txByte = rdV[1];
endmodule

// File: rtl/fpn_ctrl.sv
module fpn_ctrl
  import fpn_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              rxValid,
  input  logic              rxLast,
  output logic              txValid,
  input  logic              txReady,
  output logic              txLast,
  output logic              irq,
  input  logic [7:0]        rxByte,
  output bufStrobe_t        strobe
);
  logic busy, ictlTxd, ictlRxd, ictlTest;
  logic [PTR_W-1:0] rxCount, rxRdPtr, rxWrPtr, txCount, txWrPtr, txLen, txIdx;
  logic rxActive, rxDrop, txSending;

  logic wrIctl, softRst, rdRxDat, wrTxCnt, wrTxDat, txFinish;
  logic rxIdle, rxAccept, rxTake, rxStore, rxDone;
  logic [PTR_W-1:0] rxPos, rxLen;
  logic txdN, rxdN, testN, busyN;

  // event decode
  always_comb begin
    wrIctl   = regWr && (regAddr == OFS_ICTL);
    softRst  = wrIctl && !regWdata[0] && !regWdata[1] && regWdata[31];
    rdRxDat  = regRd && (regAddr == OFS_RXDAT) && (rxCount != '0);
    wrTxCnt  = regWr && (regAddr == OFS_TXCNT) && !txSending;
    wrTxDat  = regWr && (regAddr == OFS_TXDAT) && !txSending && (txWrPtr < txCount);
    txFinish = wrTxDat && ((txWrPtr + 1'b1) == txCount);
    rxIdle   = !rxActive && !rxDrop;
    rxAccept = rxValid && rxIdle && !busy && (rxCount < PTR_MAX) && !softRst;
    rxTake   = rxValid && (rxAccept || (rxActive && !softRst));
    rxPos    = rxAccept ? '0 : rxWrPtr;
    rxStore  = rxTake && (rxPos < PTR_MAX);
    rxDone   = rxTake && rxLast;
    rxLen    = rxStore ? rxPos + 1'b1 : rxPos;
  end

  // flag update: host action first, then hardware events merge in
  always_comb begin
    txdN  = ictlTxd;
    rxdN  = ictlRxd;
    testN = ictlTest;
    if (regRd && (regAddr == OFS_ICTL)) testN = 1'b0;
    if (wrIctl) begin
      if (regWdata[0])       txdN = 1'b0;
      else if (regWdata[1])  rxdN = 1'b0;
      else if (regWdata[31]) begin txdN = 1'b0; rxdN = 1'b0; testN = 1'b1; end
    end
    if (txFinish) txdN = 1'b1;
    if (rxDone)   rxdN = 1'b1;
    busyN = busy;
    if (wrIctl) busyN = txdN | rxdN | testN;
    if (rxAccept || txFinish) busyN = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b1;  ictlTxd <= 1'b0;  ictlRxd <= 1'b0;  ictlTest <= 1'b0;
      rxCount <= '0; rxRdPtr <= '0;  rxWrPtr <= '0;
      txCount <= '0; txWrPtr <= '0;  txLen <= '0;  txIdx <= '0;
      rxActive <= 1'b0; rxDrop <= 1'b0; txSending <= 1'b0;
    end else begin
      busy <= busyN;  ictlTxd <= txdN;  ictlRxd <= rxdN;  ictlTest <= testN;
      // receive side
      if (softRst) begin
        rxCount  <= '0;
        rxRdPtr  <= '0;
        rxActive <= 1'b0;
        rxDrop   <= (rxActive || rxDrop || rxValid) && !(rxValid && rxLast);
      end else begin
        if (rdRxDat) begin
          rxCount <= rxCount - 1'b1;
          rxRdPtr <= rxRdPtr + 1'b1;
        end
        if (rxAccept) begin
          rxCount <= '0;
          rxRdPtr <= '0;
        end
        if (rxTake) rxWrPtr <= rxLen;
        if (rxDone) begin
          rxCount <= rxLen;
          rxRdPtr <= '0;
        end
        if (rxValid) begin
          if (rxIdle) begin
            rxActive <= rxAccept && !rxLast;
            rxDrop   <= !rxAccept && !rxLast;
          end else if (rxLast) begin
            rxActive <= 1'b0;
            rxDrop   <= 1'b0;
          end
        end
      end
      // transmit loading
      if (softRst) begin
        txCount <= '0;
        txWrPtr <= '0;
      end else if (wrTxCnt) begin
        txCount <= (regWdata <= 32'(FRAME_MAX)) ? regWdata[PTR_W-1:0] : '0;
        txWrPtr <= '0;
      end else if (txFinish) begin
        txLen   <= txCount;
        txCount <= '0;
        txWrPtr <= '0;
      end else if (wrTxDat) begin
        txWrPtr <= txWrPtr + 1'b1;
      end
      // transmit streaming
      if (txFinish) begin
        txSending <= 1'b1;
        txIdx     <= '0;
      end else if (txSending && txReady) begin
        if (txLast) txSending <= 1'b0;
        else        txIdx <= txIdx + 1'b1;
      end
    end
  end

  assign txValid = txSending;
  assign txLast  = txSending && (txIdx == txLen - 1'b1);
  assign irq     = ictlTxd | ictlRxd | ictlTest;

  always_comb begin
    strobe.rxWe = rxStore;
    strobe.rxWa = rxPos;
    strobe.rxRa = rxRdPtr;
    strobe.txWe = wrTxDat;
    strobe.txWa = txWrPtr;
    strobe.txRa = txIdx;
  end

  always_comb begin
    regRdata = '0;
    if (regRd) begin
      unique case (regAddr)
        OFS_ID0:   regRdata = ID_WORD0;
        OFS_ID1:   regRdata = ID_WORD1;
        OFS_BUSY:  regRdata = {31'b0, busy};
        OFS_RXCNT: regRdata = {{(32-PTR_W){1'b0}}, rxCount};
        OFS_TXCNT: regRdata = {{(32-PTR_W){1'b0}}, txCount};
        OFS_ICTL:  regRdata = {ictlTest, 29'b0, ictlRxd, ictlTxd};
        OFS_RXDAT: regRdata = (rxCount != '0) ? {24'b0, rxByte} : '0;
        default:   regRdata = '0;
      endcase
    end
  end

  AST_TEST_RDCLR: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && !regWr && regAddr == OFS_ICTL) |=> !ictlTest); // R4
  AST_TXD_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == OFS_ICTL && regWdata[0]) |=> !ictlTxd); // R5
  AST_TXCNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= PTR_MAX); // R7
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txLast) && $stable(txIdx))); // R9
  AST_RXD_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ictlRxd) |-> ($past(rxValid && rxLast) && busy)); // R10
  AST_RX_BUSY_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxIdle && busy) |=> !rxActive); // R11
  AST_RXCNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= PTR_MAX); // R13
endmodule

// File: rtl/frame_port_nic.sv
module frame_port_nic
  import fpn_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxLast,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txData,
  output logic              txLast,
  output logic              irq
);
  bufStrobe_t strobe;
  logic [7:0] rxByte;

  fpn_ctrl ctrlI (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regRd    (regRd),
    .regWr    (regWr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .rxValid  (rxValid),
    .rxLast   (rxLast),
    .txValid  (txValid),
    .txReady  (txReady),
    .txLast   (txLast),
    .irq      (irq),
    .rxByte   (rxByte),
    .strobe   (strobe)
  );

  fpn_datapath dpI (
    .clk      (clk),
    .strobe   (strobe),
    .rxData   (rxData),
    .hostByte (regWdata[7:0]),
    .rxByte   (rxByte),
    .txByte   (txData)
  );
endmodule

// File: tb/frame_port_nic_tb_top.sv
module frame_port_nic_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  regAddr = '0;
  logic        regRd = 1'b0;
  logic        regWr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxLast = 1'b0;
  logic        txValid;
  logic        txReady = 1'b1;
  logic [7:0]  txData;
  logic        txLast;
  logic        irq;

  int total = 0;
  int bad = 0;
  int readyMode = 0;
  int rdyCnt = 0;
  bit finished = 1'b0;
  logic [8:0] expQ [$];

  always #2 clk = ~clk;

  frame_port_nic dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRd(regRd), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .rxValid(rxValid), .rxData(rxData),
    .rxLast(rxLast), .txValid(txValid), .txReady(txReady), .txData(txData),
    .txLast(txLast), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int base, input int i);
    return 8'(base * 7 + i * 13);
  endfunction

  task automatic busWr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic busRd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRd(a, v);
    check(req, v, exp);
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic rxFrame(input int len, input int base);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rxValid = 1'b1; rxData = pat(base, i); rxLast = (i == len - 1);
    end
    @(negedge clk);
    rxValid = 1'b0; rxLast = 1'b0;
  endtask

  // driver: load an outgoing frame and queue what must appear on the stream
  task automatic txFrame(input int len, input int base);
    busWr(6'h10, 32'(len));
    for (int i = 0; i < len; i++) begin
      expQ.push_back({(i == len - 1), pat(base, i)});
      busWr(6'h20, {24'h0, pat(base, i)});
    end
  endtask

  always @(negedge clk) begin
    rdyCnt <= rdyCnt + 1;
    case (readyMode)
      0: txReady <= 1'b1;
      1: txReady <= 1'b0;
      default: txReady <= rdyCnt[0];
    endcase
  end

  // monitor: compare each accepted outgoing byte with the queue head
  always @(negedge clk) begin
    #1;
    if (rstN && txValid && txReady) begin
      if (expQ.size() == 0) begin
        check("R8 unexpected tx byte", {23'h0, txLast, txData}, 32'h0);
      end else begin
        logic [8:0] e;
        e = expQ.pop_front();
        check("R8 tx byte/last", {23'h0, txLast, txData}, {23'h0, e});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R2 reset state
    settle();
    check("R2 irq", {31'h0, irq}, 32'h0);
    check("R2 txValid", {31'h0, txValid}, 32'h0);
    expectReg("R2 busy", 6'h08, 32'h1);
    expectReg("R2 rx count", 6'h0C, 32'h0);
    expectReg("R2 tx count", 6'h10, 32'h0);
    expectReg("R2 ictl", 6'h14, 32'h0);

    // R1 constant and zero offsets
    expectReg("R1 id0", 6'h00, 32'h4D495053);
    expectReg("R1 id1", 6'h04, 32'h4E455430);
    expectReg("R1 info", 6'h18, 32'h0);
    expectReg("R1 tx port", 6'h20, 32'h0);
    expectReg("R1 unmapped", 6'h3C, 32'h0);
    settle();
    check("R1 idle rdata", regRdata, 32'h0);

    // R11 frame while busy after reset is discarded
    rxFrame(4, 1);
    expectReg("R11 rx count busy", 6'h0C, 32'h0);
    expectReg("R11 ictl busy", 6'h14, 32'h0);

    // R5 zero write recomputes busy
    busWr(6'h14, 32'h0);
    expectReg("R5 busy after zero", 6'h08, 32'h0);

    // R10 R12 reception and draining
    rxFrame(6, 2);
    expectReg("R10 rx count", 6'h0C, 32'd6);
    expectReg("R10 ictl", 6'h14, 32'h2);
    expectReg("R10 busy", 6'h08, 32'h1);
    settle();
    check("R3 irq rx", {31'h0, irq}, 32'h1);
    for (int i = 0; i < 6; i++) begin
      expectReg("R12 rx byte", 6'h1C, {24'h0, pat(2, i)});
      expectReg("R12 rx count dec", 6'h0C, 32'(5 - i));
    end
    expectReg("R12 empty read", 6'h1C, 32'h0);
    expectReg("R12 empty count", 6'h0C, 32'h0);

    // R11 frame while RX-done keeps busy
    rxFrame(3, 3);
    expectReg("R11 rx count", 6'h0C, 32'h0);

    // R5 priority: bit0 wins, RX-done survives
    busWr(6'h14, 32'h3);
    expectReg("R5 priority", 6'h14, 32'h2);
    expectReg("R5 busy or", 6'h08, 32'h1);
    busWr(6'h14, 32'h2);
    expectReg("R5 rx ack", 6'h14, 32'h0);
    expectReg("R5 busy clear", 6'h08, 32'h0);
    settle();
    check("R3 irq low", {31'h0, irq}, 32'h0);

    // R7 count limits
    busWr(6'h10, 32'd3000);
    expectReg("R7 over limit", 6'h10, 32'h0);
    busWr(6'h10, 32'd1514);
    expectReg("R7 at limit", 6'h10, 32'd1514);
    busWr(6'h10, 32'd1515);
    expectReg("R7 just over", 6'h10, 32'h0);

    // R8 transmit
    txFrame(4, 5);
    repeat (10) @(negedge clk);
    check("R8 queue drained", 32'(expQ.size()), 32'h0);
    expectReg("R8 ictl", 6'h14, 32'h1);
    expectReg("R8 tx count", 6'h10, 32'h0);
    expectReg("R8 busy", 6'h08, 32'h1);
    busWr(6'h14, 32'h1);
    busWr(6'h20, 32'h55);
    settle();
    check("R8 zero-count write", {31'h0, txValid}, 32'h0);
    expectReg("R8 zero-count ictl", 6'h14, 32'h0);

    // R9 stalled stream ignores loading writes
    readyMode = 1;
    txFrame(3, 6);
    repeat (3) @(negedge clk);
    #1 check("R9 stalled valid", {31'h0, txValid}, 32'h1);
    busWr(6'h10, 32'd7);
    busWr(6'h20, 32'hEE);
    expectReg("R9 count ignored", 6'h10, 32'h0);
    readyMode = 2;
    repeat (20) @(negedge clk);
    readyMode = 0;
    check("R9 queue drained", 32'(expQ.size()), 32'h0);

    // R6 soft reset via test flag, R4 read clears it
    busWr(6'h10, 32'd5);
    busWr(6'h20, 32'h11);
    busWr(6'h20, 32'h22);
    busWr(6'h14, 32'h80000000);
    settle();
    check("R6 irq test", {31'h0, irq}, 32'h1);
    expectReg("R6 tx count", 6'h10, 32'h0);
    expectReg("R6 busy", 6'h08, 32'h1);
    expectReg("R6 ictl test", 6'h14, 32'h80000000);
    expectReg("R4 test cleared", 6'h14, 32'h0);
    settle();
    check("R3 irq after clear", {31'h0, irq}, 32'h0);

    // R14 acknowledge on the rxLast cycle
    busWr(6'h14, 32'h0);
    expQ.push_back({1'b1, 8'hA5});
    fork
      rxFrame(20, 8);
      begin
        repeat (2) @(negedge clk);
        regAddr = 6'h10; regWdata = 32'd1; regWr = 1'b1;
        @(negedge clk);
        regAddr = 6'h20; regWdata = 32'hA5;
        @(negedge clk);
        regWr = 1'b0;
        repeat (16) @(negedge clk);
        regAddr = 6'h14; regWdata = 32'h1; regWr = 1'b1;
        @(negedge clk);
        regWr = 1'b0;
      end
    join
    expectReg("R14 ictl", 6'h14, 32'h2);
    expectReg("R14 busy", 6'h08, 32'h1);
    expectReg("R14 rx count", 6'h0C, 32'd20);
    check("R14 tx drained", 32'(expQ.size()), 32'h0);

    // R13 oversize frame truncated
    busWr(6'h14, 32'h2);
    rxFrame(1516, 9);
    expectReg("R13 rx count", 6'h0C, 32'd1514);
    for (int i = 0; i < 1514; i++) begin
      expectReg("R13 rx byte", 6'h1C, {24'h0, pat(9, i)});
    end
    expectReg("R13 drained", 6'h0C, 32'h0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule